// File: doc/BRIEF.md
# Mode-Selectable One-Position Shifter

This block is a purely combinational data-path shifter. It takes a word of configurable width and a two-bit mode code. For each mode code it drives a result word and a single carry-out bit. The result is one of four things: all zeros, the word moved one place toward the LSB, the word moved one place toward the MSB, or the word unchanged.

A fill-control input applies only to the move toward the LSB. It chooses what enters the vacated MSB: a copy of the old MSB, which gives a signed halving, or a zero, which gives an unsigned halving. A move toward the MSB always brings a zero into the LSB, so it doubles the word modulo two to the power of the width. The bit that falls off the end is reported on the carry-out and is not part of the result.

Every result bit comes from its own four-way selector. The selector picks among a constant zero, the bit above it, the bit below it and its own input bit. All the selectors share the mode code. There is no clock and no reset, and the outputs depend only on the present inputs.

Top module: `one_pos_shifter`

## Requirements
- R1: Mode code 2'b00 drives `res_o` to all zeros and `cout_o` to 0.
- R2: Mode code 2'b11 drives `res_o` equal to `word_i` and `cout_o` to 0.
- R3: Mode code 2'b10 drives `res_o` to (`word_i` * 2) mod 2^W, so bit 0 of the result is 0.
- R4: Mode code 2'b10 drives `cout_o` to the old bit W-1 of `word_i`.
- R5: Mode code 2'b01 with `sfill_i` = 0 drives `res_o` to `word_i` / 2 (unsigned, rounded down), so bit W-1 of the result is 0.
- R6: Mode code 2'b01 with `sfill_i` = 1 drives `res_o` to floor(`word_i` / 2), with `word_i` read as two's complement. Bit W-1 is kept, so 4'b1110 gives 4'b1111.
- R7: Mode code 2'b01 drives `cout_o` to the old bit 0 of `word_i`.
- R8: `sfill_i` has no effect on `res_o` or `cout_o` when the mode code is 2'b00, 2'b10 or 2'b11.
- R9: The outputs follow a change on any input without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_i | input | W | Data word to be shifted |
| mode_i | input | 2 | Mode code: 00 zero, 01 toward LSB, 10 toward MSB, 11 unchanged |
| sfill_i | input | 1 | On a move toward the LSB: 1 copies the old MSB in, 0 inserts zero |
| res_o | output | W | Result word |
| cout_o | output | 1 | Bit shifted out of the word; 0 when nothing is shifted |

## Verification
Whenever an input changes, the in-RTL assertions compare the result and carry against arithmetic forms: zero, identity, doubling, logical halving and arithmetic halving. They also compare the carry against the end bit that was dropped, so R1 to R7 are checked on every settled input. The claim that the fill control is ignored in three of the modes (R8) relates two input values, and no single evaluation can show it. The same holds for the claim that results appear with no clock (R9). The bench shows both by toggling `sfill_i`, by changing inputs between samples, and by sweeping every word, mode and fill value at widths 4 and 8.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [1:0] {
    SH_CLEAR = 2'b00,
    SH_DOWN  = 2'b01,
    SH_UP    = 2'b10,
    SH_HOLD  = 2'b11
  } shift_mode_e;

  // Bit entering the vacated MSB on a move toward the LSB.
  function automatic logic top_fill(input logic msb, input logic sign_fill);
    return sign_fill & msb;
  endfunction

endpackage

// File: rtl/shift_neighbour_taps.sv
module shift_neighbour_taps #(
  parameter int W = 4
) (
  input  logic [W-1:0] word,
  input  logic         sign_fill,
  output logic [W-1:0] upper_nb,
  output logic [W-1:0] lower_nb
);
  import shifter_pkg::*;

  localparam int TOP = W - 1;

  logic fill_in;
  assign fill_in = top_fill(word[TOP], sign_fill);

  for (genvar b = 0; b < W; b++) begin : g_tap
    if (b == TOP) begin : g_top
      assign upper_nb[b] = fill_in;
    end else begin : g_mid_up
      assign upper_nb[b] = word[b+1];
    end
    if (b == 0) begin : g_bot
      assign lower_nb[b] = 1'b0;
    end else begin : g_mid_lo
      assign lower_nb[b] = word[b-1];
    end
  end

endmodule

// File: rtl/shift_bit_mux.sv
module shift_bit_mux
  import shifter_pkg::*;
(
  input  shift_mode_e sel,
  input  logic        self_bit,
  input  logic        upper_bit,
  input  logic        lower_bit,
  output logic        y
);

  always_comb begin
    unique case (sel)
      SH_CLEAR: y = 1'b0;
      SH_DOWN:  y = upper_bit;
      SH_UP:    y = lower_bit;
      SH_HOLD:  y = self_bit;
      default:  y = 1'b0;
    endcase
  end

endmodule

// File: rtl/shift_carry_sel.sv
module shift_carry_sel
  import shifter_pkg::*;
(
  input  shift_mode_e sel,
  input  logic        msb,
  input  logic        lsb,
  output logic        carry
);

  always_comb begin
    unique case (sel)
      SH_DOWN: carry = lsb;
      SH_UP:   carry = msb;
      default: carry = 1'b0;
    endcase
  end

endmodule

// File: rtl/one_pos_shifter.sv
module one_pos_shifter #(
  parameter int W = 4
) (
  input  logic [W-1:0] word_i,
  input  logic [1:0]   mode_i,
  input  logic         sfill_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  import shifter_pkg::*;

  localparam int TOP = W - 1;

  shift_mode_e sel;
  logic [W-1:0] upper_nb;
  logic [W-1:0] lower_nb;
  logic         dropped_top;
  logic         dropped_bot;

  assign sel         = shift_mode_e'(mode_i);
  assign dropped_top = word_i[TOP];
  assign dropped_bot = word_i[0];

  shift_neighbour_taps #(.W(W)) u_taps (
    .word      (word_i),
    .sign_fill (sfill_i),
    .upper_nb  (upper_nb),
    .lower_nb  (lower_nb)
  );

  for (genvar b = 0; b < W; b++) begin : g_bit
    shift_bit_mux u_mux (
      .sel       (sel),
      .self_bit  (word_i[b]),
      .upper_bit (upper_nb[b]),
      .lower_bit (lower_nb[b]),
      .y         (res_o[b])
    );
  end

  shift_carry_sel u_carry (
    .sel   (sel),
    .msb   (dropped_top),
    .lsb   (dropped_bot),
    .carry (cout_o)
  );

  // Arithmetic forms used by the assertions.
  function automatic logic [W-1:0] arith_double(input logic [W-1:0] v);
    return W'(v * 2);
  endfunction

  function automatic logic [W-1:0] arith_half_u(input logic [W-1:0] v);
    return v / 2;
  endfunction

  function automatic logic [W-1:0] arith_half_s(input logic [W-1:0] v);
    logic signed [W-1:0] sv;
    sv = $signed(v);
    return W'(sv >>> 1);
  endfunction

  always_comb begin
    if (sel == SH_CLEAR) begin
      // R1
      zero_mode_chk: assert (res_o == '0 && cout_o == 1'b0)
        else $error("zero mode gave %0h/%0b", res_o, cout_o);
    end
    if (sel == SH_HOLD) begin
      // R2
      pass_mode_chk: assert (res_o == word_i && cout_o == 1'b0)
        else $error("pass mode gave %0h/%0b", res_o, cout_o);
    end
    if (sel == SH_UP) begin
      // R3
      double_chk: assert (res_o == arith_double(word_i))
        else $error("left shift gave %0h", res_o);
      // R4
      up_carry_chk: assert (cout_o == word_i[TOP])
        else $error("left carry %0b", cout_o);
    end
    if (sel == SH_DOWN) begin
      if (!sfill_i) begin
        // R5
        half_u_chk: assert (res_o == arith_half_u(word_i))
          else $error("logical right gave %0h", res_o);
      end else begin
        // R6
        half_s_chk: assert (res_o == arith_half_s(word_i))
          else $error("arith right gave %0h", res_o);
      end
      // R7
      down_carry_chk: assert (cout_o == word_i[0])
        else $error("right carry %0b", cout_o);
    end
  end

endmodule

// File: tb/sim_one_pos_shifter.sv
module sim_one_pos_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] w4_in;
  logic [1:0] w4_mode;
  logic       w4_fill;
  logic [3:0] w4_res;
  logic       w4_cout;

  logic [7:0] w8_in;
  logic [1:0] w8_mode;
  logic       w8_fill;
  logic [7:0] w8_res;
  logic       w8_cout;

  one_pos_shifter #(.W(4)) u0 (
    .word_i (w4_in), .mode_i (w4_mode), .sfill_i (w4_fill),
    .res_o  (w4_res), .cout_o (w4_cout)
  );

  one_pos_shifter #(.W(8)) u8 (
    .word_i (w8_in), .mode_i (w8_mode), .sfill_i (w8_fill),
    .res_o  (w8_res), .cout_o (w8_cout)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected result computed arithmetically from the requirements.
  function automatic int exp_res(input int w, input int v, input int m, input int f);
    int span, sv, q;
    span = 1 << w;
    case (m)
      0: return 0;
      3: return v;
      2: return (v * 2) % span;
      default: begin
        if (f == 0) return v / 2;
        sv = (v >= span / 2) ? v - span : v;
        q  = (sv >= 0) ? sv / 2 : -((1 - sv) / 2);
        return ((q % span) + span) % span;
      end
    endcase
  endfunction

  function automatic int exp_cout(input int w, input int v, input int m);
    case (m)
      2: return (v >> (w - 1)) & 1;
      1: return v & 1;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int m, input int f, input bit carry);
    case (m)
      0: return "R1";
      3: return "R2";
      2: return carry ? "R4" : "R3";
      default: return carry ? "R7" : (f != 0 ? "R6" : "R5");
    endcase
  endfunction

  initial begin
    w4_in = '0; w4_mode = 2'b00; w4_fill = 1'b0;
    w8_in = '0; w8_mode = 2'b00; w8_fill = 1'b0;
    @(negedge clk);
    // Idle state after power-up: zero mode, zero word (R1)
    check("R1", int'(w4_res), 0);
    check("R1", int'(w8_cout), 0);

    // Named corner cases
    w4_in = 4'b0111; w4_mode = 2'b01; w4_fill = 1'b0; #1;
    check("R5", int'(w4_res), 3);
    check("R7", int'(w4_cout), 1);
    w4_in = 4'b1110; w4_fill = 1'b1; #1;
    check("R6", int'(w4_res), 15);
    w4_in = 4'b1010; w4_mode = 2'b10; #1;
    check("R3", int'(w4_res), 4);
    check("R4", int'(w4_cout), 1);

    // R9: outputs move with inputs between edges, no clock needed
    @(negedge clk);
    w4_in = 4'b0001; w4_mode = 2'b11; #1;
    check("R9", int'(w4_res), 1);
    w4_in = 4'b1001; #1;
    check("R9", int'(w4_res), 9);

    // Exhaustive sweep, width 4
    for (int v = 0; v < 16; v++) begin
      for (int m = 0; m < 4; m++) begin
        for (int f = 0; f < 2; f++) begin
          @(negedge clk);
          w4_in = 4'(v); w4_mode = 2'(m); w4_fill = f[0];
          #1;
          check(req_of(m, f, 1'b0), int'(w4_res), exp_res(4, v, m, f));
          check(req_of(m, f, 1'b1), int'(w4_cout), exp_cout(4, v, m));
        end
      end
    end

    // Exhaustive sweep, width 8, plus R8 fill toggle in other modes
    for (int v = 0; v < 256; v++) begin
      for (int m = 0; m < 4; m++) begin
        for (int f = 0; f < 2; f++) begin
          @(negedge clk);
          w8_in = 8'(v); w8_mode = 2'(m); w8_fill = f[0];
          #1;
          check(req_of(m, f, 1'b0), int'(w8_res), exp_res(8, v, m, f));
          check(req_of(m, f, 1'b1), int'(w8_cout), exp_cout(8, v, m));
          if (m != 1) begin
            w8_fill = ~w8_fill; #1;
            check("R8", int'(w8_res), exp_res(8, v, m, 0));
            check("R8", int'(w8_cout), exp_cout(8, v, m));
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule